// File: doc/BRIEF.md
# Radix-4 Quotient and Root Digit Selector

This block chooses the next result digit of a shared radix-4 divide and square-root recurrence. Each iteration it receives the residual in carry-save form (a sum vector and a carry vector), the divisor, the partial root, an operation select and the iteration index. It adds the leading residual bits in a short carry-propagate adder to form a signed estimate. It then picks one column of a threshold table and compares the estimate against the four thresholds of that column.

The column comes from the divisor during division and from the partial root during square root. One table serves both operations. The chosen digit, in the set {-2,-1,0,+1,+2}, is held in a 4-bit register using a one-out-of-four code. The surrounding recurrence pulses `start` once at the beginning of an operation, which loads the digit +1. It pulses `step` once per iteration to capture the newly selected digit.

Top module: `rdx4_digit_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `digit_code` is 4'b0000.
- R2: A cycle with `start` high loads +1 (4'b0010) into the digit register. `start` takes priority over `step`.
- R3: A cycle with `step` high and `start` low registers the digit selected in that cycle. The digit is the largest h in {+2,+1,0,-1} whose threshold m_h satisfies m_h <= y, and -2 when no threshold does. With neither `start` nor `step` high, the register holds its value.
- R4: The estimate y is formed in two stages. First the top 8 bits of `wsum` and the top 8 bits of `wcarry` are added modulo 256. Then the upper 7 bits of that sum are read as a two's-complement integer in units of 1/16. The lowest bit of the sum is dropped.
- R5: In division (`is_sqrt`=0), the column index is `divisor[DIV_W-2:DIV_W-4]`, which are the divisor bits of weight 2^-2, 2^-3 and 2^-4 for a divisor whose top bit has weight 2^-1. Index 0 stands for 8/16 and index 7 for 15/16. The root input has no effect.
- R6: In square root when `iter_idx` is 0, the column index is 4 (bits 1,0,0).
- R7: In square root when `iter_idx` is not 0 and the root integer bit `root[ROOT_W-1]` is 1, the column index is 7.
- R8: In square root when `iter_idx` is not 0 and `root[ROOT_W-1]` is 0, the column index is `root[ROOT_W-3:ROOT_W-5]`, the root bits of weight 2^-2, 2^-3 and 2^-4.
- R9: `digit_code` bits 3..0 carry {minus-two, minus-one, plus-one, plus-two}. The codes are +2 = 0001, +1 = 0010, 0 = 0000, -1 = 0100 and -2 = 1000, so at most one bit is ever set.
- R10: The thresholds, in units of 1/16, for columns 0..7 are as follows. m2: 12,14,15,16,18,20,20,22. m1: 4,4,4,4,6,6,8,8. m0: -4,-5,-6,-6,-6,-8,-8,-8. m-1: -13,-15,-16,-17,-18,-20,-22,-23. An estimate equal to a threshold selects that threshold's digit.
- R11: Residual bits below the top 8 of `wsum` and `wcarry` have no effect on the selected digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the initial digit +1 |
| step | input | 1 | Capture the selected digit |
| is_sqrt | input | 1 | 1 = square root, 0 = division |
| iter_idx | input | ITER_W | Iteration index j |
| wsum | input | RES_W | Residual sum vector |
| wcarry | input | RES_W | Residual carry vector |
| divisor | input | DIV_W | Normalised divisor, top bit weight 2^-1 |
| root | input | ROOT_W | Partial root, top bit is the integer bit |
| digit_code | output | 4 | Registered digit, one-out-of-four code |

## Verification
The assertions check four properties on every cycle. The code never has more than one bit set. A start always yields +1. Without start or step the register holds. Estimates above every threshold give +2, and estimates below every threshold give -2. Only the bench's scenarios can show the following. Each threshold is exact at its boundary in both the division and the square-root columns. The column follows the iteration and the root integer bit. Carries and wrap-around in the estimate adder behave as specified. The lower residual bits, and the unused operand, have no effect.

// File: rtl/rdx4_sel_pkg.sv
package rdx4_sel_pkg;
   typedef logic [3:0] dcode_t;

   localparam dcode_t CODE_P2 = 4'b0001;
   localparam dcode_t CODE_P1 = 4'b0010;
   localparam dcode_t CODE_Z  = 4'b0000;
   localparam dcode_t CODE_M1 = 4'b0100;
   localparam dcode_t CODE_M2 = 4'b1000;

   localparam int NUM_COLS = 8;
   localparam int NUM_THR  = 4;

   // level 0 = m2, 1 = m1, 2 = m0, 3 = m-1; values scaled by 16
   function automatic logic signed [7:0] thr_val(input int level, input int col);
      logic signed [7:0] v;
      v = '0;
      case (level)
         0: case (col)
               0: v = 8'sd12; 1: v = 8'sd14; 2: v = 8'sd15; 3: v = 8'sd16;
               4: v = 8'sd18; 5: v = 8'sd20; 6: v = 8'sd20; default: v = 8'sd22;
            endcase
         1: case (col)
               0, 1, 2, 3: v = 8'sd4;
               4, 5:       v = 8'sd6;
               default:    v = 8'sd8;
            endcase
         2: case (col)
               0:          v = -8'sd4;
               1:          v = -8'sd5;
               2, 3, 4:    v = -8'sd6;
               default:    v = -8'sd8;
            endcase
         default: case (col)
               0: v = -8'sd13; 1: v = -8'sd15; 2: v = -8'sd16; 3: v = -8'sd17;
               4: v = -8'sd18; 5: v = -8'sd20; 6: v = -8'sd22; default: v = -8'sd23;
            endcase
      endcase
      return v;
   endfunction
endpackage

// File: rtl/rdx4_est_adder.sv
module rdx4_est_adder #(
   parameter int ADD_W      = 8,
   parameter int ADDER_KIND = 0
) (
   input  logic [ADD_W-1:0] a_in,
   input  logic [ADD_W-1:0] b_in,
   output logic [ADD_W-1:0] sum_out
);
   generate
      if (ADDER_KIND == 0) begin : g_behav
         assign sum_out = a_in + b_in;
      end else begin : g_ripple
         logic [ADD_W:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < ADD_W; i++) begin : g_bit
            assign sum_out[i] = a_in[i] ^ b_in[i] ^ cy[i];
            assign cy[i+1]    = (a_in[i] & b_in[i]) | (cy[i] & (a_in[i] ^ b_in[i]));
         end
      end
   endgenerate
endmodule

// File: rtl/rdx4_col_pick.sv
module rdx4_col_pick #(
   parameter int DIV_W  = 56,
   parameter int ROOT_W = 56,
   parameter int ITER_W = 5
) (
   input  logic              is_sqrt,
   input  logic [ITER_W-1:0] iter_idx,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [ROOT_W-1:0] root,
   output logic [2:0]        col
);
   localparam int RI = ROOT_W - 1;   // integer bit of the root
   localparam int DT = DIV_W - 2;    // divisor bit of weight 2^-2

   logic       first_iter;
   logic [2:0] div_col;
   logic [2:0] root_col;

   assign first_iter = (iter_idx == '0);
   assign div_col    = divisor[DT -: 3];

   always_comb begin
      if (first_iter)
         root_col = 3'b100;
      else if (root[RI])
         root_col = 3'b111;
      else
         root_col = root[RI-2 -: 3];
   end

   assign col = is_sqrt ? root_col : div_col;
endmodule

// File: rtl/rdx4_thr_cmp.sv
module rdx4_thr_cmp
   import rdx4_sel_pkg::*;
#(
   parameter int EST_W = 7
) (
   input  logic signed [EST_W-1:0] est,
   input  logic [2:0]              col,
   output dcode_t                  code
);
   logic signed [7:0] est_x;
   logic [NUM_THR-1:0] ge;

   assign est_x = 8'(est);

   generate
      for (genvar h = 0; h < NUM_THR; h++) begin : g_lvl
         logic signed [7:0] col_thr [NUM_COLS];
         for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            assign col_thr[c] = thr_val(h, c);
         end
         assign ge[h] = (est_x >= col_thr[col]);
      end
   endgenerate

   always_comb begin
      if (ge[0])      code = CODE_P2;
      else if (ge[1]) code = CODE_P1;
      else if (ge[2]) code = CODE_Z;
      else if (ge[3]) code = CODE_M1;
      else            code = CODE_M2;
   end
endmodule

// File: rtl/rdx4_digit_sel.sv
module rdx4_digit_sel
   import rdx4_sel_pkg::*;
#(
   parameter int RES_W      = 56,
   parameter int DIV_W      = 56,
   parameter int ROOT_W     = 56,
   parameter int ITER_W     = 5,
   parameter int ADD_W      = 8,
   parameter int ADDER_KIND = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic              is_sqrt,
   input  logic [ITER_W-1:0] iter_idx,
   input  logic [RES_W-1:0]  wsum,
   input  logic [RES_W-1:0]  wcarry,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [ROOT_W-1:0] root,
   output logic [3:0]        digit_code
);
   localparam int EST_W = ADD_W - 1;
   localparam int TOP   = RES_W - 1;

   generate
      if (ADD_W != 8) begin : g_bad_add
         $error("rdx4_digit_sel: ADD_W must be 8 for the fixed threshold table");
      end
      if (RES_W < ADD_W) begin : g_bad_res
         $error("rdx4_digit_sel: RES_W must be at least ADD_W");
      end
      if (DIV_W < 4) begin : g_bad_div
         $error("rdx4_digit_sel: DIV_W must be at least 4");
      end
      if (ROOT_W < 5) begin : g_bad_root
         $error("rdx4_digit_sel: ROOT_W must be at least 5");
      end
      if (ITER_W < 1) begin : g_bad_iter
         $error("rdx4_digit_sel: ITER_W must be at least 1");
      end
   endgenerate

   logic [ADD_W-1:0]        est_sum;
   logic signed [EST_W-1:0] est;
   logic [2:0]              col;
   dcode_t                  sel_code;
   dcode_t                  dig_q;

   rdx4_est_adder #(.ADD_W(ADD_W), .ADDER_KIND(ADDER_KIND)) u_add (
      .a_in    (wsum[TOP -: ADD_W]),
      .b_in    (wcarry[TOP -: ADD_W]),
      .sum_out (est_sum)
   );

   assign est = est_sum[ADD_W-1:1];

   rdx4_col_pick #(.DIV_W(DIV_W), .ROOT_W(ROOT_W), .ITER_W(ITER_W)) u_col (
      .is_sqrt  (is_sqrt),
      .iter_idx (iter_idx),
      .divisor  (divisor),
      .root     (root),
      .col      (col)
   );

   rdx4_thr_cmp #(.EST_W(EST_W)) u_cmp (
      .est  (est),
      .col  (col),
      .code (sel_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         dig_q <= CODE_Z;
      else if (start)
         dig_q <= CODE_P1;
      else if (step)
         dig_q <= sel_code;
   end

   assign digit_code = dig_q;
endmodule

// File: rtl/rdx4_digit_sel_chk.sv
module rdx4_digit_sel_chk #(
   parameter int ADD_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             step,
   input logic [ADD_W-1:0] ws_top,
   input logic [ADD_W-1:0] wc_top,
   input logic [3:0]       code
);
   logic [ADD_W-1:0]        raw;
   logic signed [ADD_W-2:0] y;
   assign raw = ws_top + wc_top;
   assign y   = raw[ADD_W-1:1];

   a_r9_code_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(code));

   a_r2_start_loads_plus1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> code == 4'b0010);

   a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !step) |=> $stable(code));

   a_r3_top_gives_plus2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && y >= 23) |=> code == 4'b0001);

   a_r3_bottom_gives_minus2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && y < -23) |=> code == 4'b1000);
endmodule

bind rdx4_digit_sel rdx4_digit_sel_chk #(.ADD_W(ADD_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .step   (step),
   .ws_top (wsum[RES_W-1 -: ADD_W]),
   .wc_top (wcarry[RES_W-1 -: ADD_W]),
   .code   (digit_code)
);

// File: tb/rdx4_digit_sel_test.sv
module rdx4_digit_sel_test;
   localparam int CLK_PERIOD = 10;
   localparam int RES_W  = 56;
   localparam int DIV_W  = 56;
   localparam int ROOT_W = 56;
   localparam int ITER_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              step = 1'b0;
   logic              is_sqrt = 1'b0;
   logic [ITER_W-1:0] iter_idx = '0;
   logic [RES_W-1:0]  wsum = '0;
   logic [RES_W-1:0]  wcarry = '0;
   logic [DIV_W-1:0]  divisor = '0;
   logic [ROOT_W-1:0] root = '0;
   logic [3:0]        digit_code;

   int checks = 0;
   int errors = 0;

   rdx4_digit_sel uut (
      .clk(clk), .rst_n(rst_n), .start(start), .step(step), .is_sqrt(is_sqrt),
      .iter_idx(iter_idx), .wsum(wsum), .wcarry(wcarry), .divisor(divisor),
      .root(root), .digit_code(digit_code)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // vector: sqrt(1) first(1) ws8(8) wc8(8) col(3) aint(1) exp(4) = 26 bits
   localparam int NV = 26;
   localparam logic [25:0] VEC [NV] = '{
      {1'b0,1'b0,8'h18,8'h00,3'd0,1'b0,4'b0001}, // R10 col0 y=12 -> +2
      {1'b0,1'b0,8'h16,8'h00,3'd0,1'b0,4'b0010}, // col0 y=11 -> +1
      {1'b0,1'b0,8'h08,8'h00,3'd0,1'b0,4'b0010}, // R10 y=4 -> +1
      {1'b0,1'b0,8'h06,8'h00,3'd0,1'b0,4'b0000}, // y=3 -> 0
      {1'b0,1'b0,8'hF8,8'h00,3'd0,1'b0,4'b0000}, // R10 y=-4 -> 0
      {1'b0,1'b0,8'hF6,8'h00,3'd0,1'b0,4'b0100}, // y=-5 -> -1
      {1'b0,1'b0,8'hE6,8'h00,3'd0,1'b0,4'b0100}, // R10 y=-13 -> -1
      {1'b0,1'b0,8'hE4,8'h00,3'd0,1'b0,4'b1000}, // y=-14 -> -2
      {1'b0,1'b0,8'h2A,8'h00,3'd7,1'b0,4'b0010}, // R5 col7 y=21 -> +1
      {1'b0,1'b0,8'h2C,8'h00,3'd7,1'b0,4'b0001}, // col7 y=22 -> +2
      {1'b0,1'b0,8'hD2,8'h00,3'd7,1'b0,4'b0100}, // col7 y=-23 -> -1
      {1'b0,1'b0,8'hD0,8'h00,3'd7,1'b0,4'b1000}, // col7 y=-24 -> -2
      {1'b0,1'b0,8'h0E,8'h00,3'd7,1'b0,4'b0000}, // col7 y=7 -> 0
      {1'b0,1'b0,8'h30,8'h10,3'd3,1'b0,4'b0001}, // R4 carry sum 64 y=32 -> +2
      {1'b0,1'b0,8'hF0,8'h20,3'd3,1'b0,4'b0010}, // R4 wrap sum 16 y=8 -> +1
      {1'b0,1'b0,8'h19,8'h00,3'd0,1'b0,4'b0001}, // R4 lsb dropped y=12 -> +2
      {1'b0,1'b0,8'h17,8'h00,3'd0,1'b0,4'b0010}, // R4 y=11 -> +1
      {1'b0,1'b1,8'h18,8'h00,3'd0,1'b0,4'b0001}, // R5 div j=0 col0 -> +2
      {1'b1,1'b1,8'h24,8'h00,3'd7,1'b0,4'b0001}, // R6 j=0 col4 y=18 -> +2
      {1'b1,1'b1,8'h0C,8'h00,3'd7,1'b0,4'b0010}, // R6 j=0 col4 y=6 -> +1
      {1'b1,1'b0,8'h2A,8'h00,3'd0,1'b1,4'b0010}, // R7 col7 y=21 -> +1
      {1'b1,1'b0,8'hD2,8'h00,3'd0,1'b1,4'b0100}, // R7 col7 y=-23 -> -1
      {1'b1,1'b0,8'h1E,8'h00,3'd2,1'b0,4'b0001}, // R8 col2 y=15 -> +2
      {1'b1,1'b0,8'h1C,8'h00,3'd2,1'b0,4'b0010}, // R8 col2 y=14 -> +1
      {1'b1,1'b0,8'hE0,8'h00,3'd2,1'b0,4'b0100}, // R8 col2 y=-16 -> -1
      {1'b1,1'b0,8'hDE,8'h00,3'd2,1'b0,4'b1000}  // R8 col2 y=-17 -> -2
   };

   task automatic check(input string req, input logic [3:0] exp);
      checks++;
      if (digit_code !== exp) begin
         errors++;
         $display("FAIL %s: digit_code=%b expected=%b", req, digit_code, exp);
      end
   endtask

   // sets operands; division gets a root pointing at column 7, square root a divisor at column 0
   task automatic set_ops(input logic sq, input logic first, input logic [7:0] ws8,
                          input logic [7:0] wc8, input logic [2:0] col, input logic aint);
      is_sqrt  = sq;
      iter_idx = first ? '0 : ITER_W'(3);
      wsum     = '0;
      wcarry   = '0;
      wsum[RES_W-1 -: 8]   = ws8;
      wcarry[RES_W-1 -: 8] = wc8;
      if (sq) begin
         divisor = '0;
         divisor[DIV_W-1] = 1'b1;
         root = '0;
         root[ROOT_W-1] = aint;
         root[ROOT_W-2] = 1'b1;
         root[ROOT_W-3 -: 3] = col;
      end else begin
         root = '1;
         divisor = '0;
         divisor[DIV_W-1] = 1'b1;
         divisor[DIV_W-2 -: 3] = col;
      end
   endtask

   task automatic pulse_step();
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: timeout actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      @(negedge clk);
      check("R1 in reset", 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 4'b0000);

      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 start loads +1", 4'b0010);

      foreach (VEC[i]) begin
         set_ops(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8],
                 VEC[i][7:5], VEC[i][4]);
         pulse_step();
         check($sformatf("R3/R10 vector %0d", i), VEC[i][3:0]);
      end

      // R2: start has priority over step
      set_ops(1'b0, 1'b0, 8'hE4, 8'h00, 3'd0, 1'b0);
      start = 1'b1;
      step  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      step  = 1'b0;
      check("R2 start over step", 4'b0010);

      // R3: hold without step while inputs change
      set_ops(1'b0, 1'b0, 8'h3E, 8'h00, 3'd0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      check("R3 hold", 4'b0010);

      // R11: lower residual bits ignored (col0 y=3 -> 0, lower bits all ones)
      set_ops(1'b0, 1'b0, 8'h06, 8'h00, 3'd0, 1'b0);
      wsum[RES_W-9:0]   = '1;
      wcarry[RES_W-9:0] = '1;
      pulse_step();
      check("R11 lower bits ignored", 4'b0000);

      // R5: root has no effect in division (root all zero vs all ones)
      set_ops(1'b0, 1'b0, 8'h2A, 8'h00, 3'd0, 1'b0);
      root = '0;
      pulse_step();
      check("R5 root ignored in division", 4'b0001);

      // R9: minus-two code
      set_ops(1'b0, 1'b0, 8'h80, 8'h00, 3'd5, 1'b0);
      pulse_step();
      check("R9 minimum estimate -2", 4'b1000);

      // R1: reset clears register
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears", 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule